// File: doc/BRIEF.md
# DMA Channel Interrupt Enable and Pending Registers

This block holds the interrupt enable and pending state for a sixteen-channel DMA engine. Every channel owns a group of four interrupt sources, so eight channels fill one 32-bit register. Channels 0 to 7 use the first enable register and the first pending register. Channels 8 to 15 use the second pair. The channel engines report events on a flat event vector, one bit per source. An event is latched into its pending bit only when the matching enable bit is set. Software clears a pending bit by writing a one to it.

Source 2 of each group is the queue-done interrupt. It is latched only for a channel whose transfer is running, which the engine signals on a per-channel run input. Because of this, enabling the queue-done source on every channel up front is harmless. A single interrupt line, the OR of all pending bits, goes to the interrupt controller. Software typically reads a pending register, services the channels it finds, and writes the same value back to acknowledge them.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, both enable registers and both pending registers read 0 and `irq_o` is low.
- R2: Channel ch owns bits 4*(ch mod 8) to 4*(ch mod 8)+3 of register ch/8. Register address 0 and 1 select the enable registers and address 2 and 3 select the pending registers. Event input bit 4*ch+k is source k of channel ch.
- R3: A pending bit becomes 1 on the clock edge at which its event bit is 1 and its enable bit is 1. It never becomes 1 otherwise, and it then holds until cleared.
- R4: The queue-done source is k=2 (register bit 4*(ch mod 8)+2). Its pending bit is set only if `chan_run[ch]` is 1 at that edge, even when the bit is enabled.
- R5: Writing a one to a pending bit clears it at the write edge. Writing back the value just read clears every bit that was set.
- R6: Writing a zero to a pending bit leaves it unchanged. The enable registers are plain read/write storage, and writing them never changes a pending bit.
- R7: If an event and a one-write clear hit the same pending bit at the same edge, the bit ends up set.
- R8: `irq_o` is 1 exactly when at least one pending bit in either register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select (0,1 enable; 2,3 pending) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Combinational read data |
| evt_i | input | 64 | Per-source event pulses, bit 4*ch+k |
| chan_run | input | 16 | Channel has a transfer running |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes, clears and event captures all take effect at the edge at which they are presented. Their results are due in `rd_data` and `irq_o` one edge later. The read path is combinational, so a read shows the stored state at once. The bench drives each stimulus at a falling edge and lets one rising edge pass. At the next falling edge it sweeps `rd_addr` over all four registers and compares each value, and `irq_o`, with a bench model that it updated for that same edge. The directed cases set up an event and a clear at the same edge, a queue-done event on a channel that is not running, and a write-back acknowledge. The bench checks each of these outcomes against literal expected values.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH    = 16,
  parameter int GRP_W     = 4,
  parameter int QDONE_BIT = 2,
  parameter int REG_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [1:0]                rd_addr,
  output logic [REG_W-1:0]          rd_data,
  input  logic [NUM_CH*GRP_W-1:0]   evt_i,
  input  logic [NUM_CH-1:0]         chan_run,
  output logic                      irq_o
);
  localparam int TOT_W   = NUM_CH * GRP_W;
  localparam int NUM_REG = TOT_W / REG_W;

  logic [TOT_W-1:0] en_q, pend_q, clr_mask, run_gate, en_wdata, en_wmask;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar k = 0; k < GRP_W; k++) begin : g_src
      if (k == QDONE_BIT) begin : g_q
        assign run_gate[ch*GRP_W+k] = chan_run[ch];
      end else begin : g_o
        assign run_gate[ch*GRP_W+k] = 1'b1;
      end
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    assign en_wmask[r*REG_W +: REG_W] = {REG_W{wr_en && wr_addr == 2'(r)}};
    assign en_wdata[r*REG_W +: REG_W] = wr_data;
    assign clr_mask[r*REG_W +: REG_W] =
      (wr_en && wr_addr == 2'(r + NUM_REG)) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= (en_q & ~en_wmask) | (en_wdata & en_wmask);
      pend_q <= (pend_q & ~clr_mask) | (evt_i & en_q & run_gate);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (rd_addr == 2'(r))           rd_data = en_q[r*REG_W +: REG_W];
      if (rd_addr == 2'(r + NUM_REG)) rd_data = pend_q[r*REG_W +: REG_W];
    end
  end

  assign irq_o = |pend_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int NUM_CH    = 16,
  parameter int GRP_W     = 4,
  parameter int QDONE_BIT = 2,
  parameter int REG_W     = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_addr,
  input logic [REG_W-1:0]        wr_data,
  input logic [NUM_CH*GRP_W-1:0] evt_i,
  input logic [NUM_CH-1:0]       chan_run,
  input logic [NUM_CH*GRP_W-1:0] en_q,
  input logic [NUM_CH*GRP_W-1:0] pend_q,
  input logic                    irq_o
);
  localparam int TOT_W = NUM_CH * GRP_W;
  logic [TOT_W-1:0] qmask, qrun;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_m
    for (genvar k = 0; k < GRP_W; k++) begin : g_k
      assign qmask[ch*GRP_W+k] = (k == QDONE_BIT);
      assign qrun[ch*GRP_W+k]  = (k == QDONE_BIT) && chan_run[ch];
    end
  end

  p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(en_q & evt_i)) == '0);

  p_qdone_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & $past(qmask & ~qrun)) == '0);

  p_w1c_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == 2'd2 && evt_i == '0) |->
      (pend_q[REG_W-1:0] & $past(wr_data)) == '0);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(en_q & evt_i & (~qmask | qrun))) == $past(en_q & evt_i & (~qmask | qrun)));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(en_q & evt_i)));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH), .GRP_W(GRP_W),
  .QDONE_BIT(QDONE_BIT), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .evt_i(evt_i), .chan_run(chan_run),
  .en_q(en_q), .pend_q(pend_q), .irq_o(irq_o));

// File: tb/dma_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [63:0] evt_i = 0;
  logic [15:0] chan_run = 0;
  logic irq_o;
  logic [63:0] en_m = 0, pend_m = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt_i),
    .chan_run(chan_run), .irq_o(irq_o));

  function automatic logic [63:0] gate_of(logic [15:0] run);
    logic [63:0] g = '1;
    for (int ch = 0; ch < 16; ch++) g[ch*4+2] = run[ch];
    return g;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    return a < 2 ? en_m[a*32 +: 32] : pend_m[(a-2)*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  // drive at negedge, model the rising edge, check at next negedge
  task automatic cycle(logic we, logic [1:0] wa, logic [31:0] wd,
                       logic [63:0] ev, logic [15:0] run);
    logic [63:0] clr = '0, nen = en_m;
    logic [31:0] v;
    wr_en = we; wr_addr = wa; wr_data = wd; evt_i = ev; chan_run = run;
    if (we && wa >= 2) clr[(wa-2)*32 +: 32] = wd;
    if (we && wa < 2) nen[wa*32 +: 32] = wd;
    @(posedge clk);
    pend_m = (pend_m & ~clr) | (ev & en_m & gate_of(run));
    en_m = nen;
    @(negedge clk);
    wr_en = 0; evt_i = 0;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(a < 2 ? "R6 enable" : "R3 pending", v, exp_rd(2'(a)));
    end
    chk("R8 irq", {31'd0, irq_o}, {31'd0, pend_m != 0});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reset", v, 32'h0); end
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    // R2 channel 9 queue bit sits at bit 6 of register 1
    cycle(1, 2'd1, 32'h0000_0040, 64'h0, 16'h0);
    cycle(0, 2'd0, 0, 64'd1 << 38, 16'h0200);
    rd(2'd3, v); chk("R2 ch9 pend1", v, 32'h0000_0040);
    rd(2'd2, v); chk("R2 ch9 pend0", v, 32'h0);
    chk("R8 irq high", {31'd0, irq_o}, 32'd1);
    // R5 write back acknowledge
    rd(2'd3, v);
    cycle(1, 2'd3, v, 64'h0, 16'h0);
    rd(2'd3, v); chk("R5 writeback", v, 32'h0);
    chk("R8 irq low", {31'd0, irq_o}, 32'd0);
    // R4 queue-done on idle channel 3 is dropped, source 0 is kept
    cycle(1, 2'd0, 32'h0000_5000, 64'h0, 16'h0);
    cycle(0, 2'd0, 0, 64'h0000_5000, 16'h0);
    rd(2'd2, v); chk("R4 idle qdone", v, 32'h0000_1000);
    // R6 zero write keeps, R7 event beats clear
    cycle(1, 2'd2, 32'h0, 64'h0, 16'h0);
    rd(2'd2, v); chk("R6 zero write", v, 32'h0000_1000);
    cycle(1, 2'd2, 32'h0000_1000, 64'h0000_1000, 16'h0);
    rd(2'd2, v); chk("R7 event wins", v, 32'h0000_1000);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ev = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      logic [1:0] wa = 2'($urandom);
      logic [31:0] wd = $urandom;
      if (wa >= 2 && ($urandom % 2)) wd = exp_rd(wa);
      cycle(1'($urandom), wa, wd, ev, 16'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule